// File: doc/BRIEF.md
# Serial Watchpoint Register Access Port

This block is the serial back door to the watchpoint register file. An external test-access controller drives three strobes (shift, capture, update), a serial input and receives a serial output. A 38-bit chain moves one bit per shift strobe, least significant bit first. On an update strobe the chain is read as a packet: a direction bit, a 5-bit register address and a 32-bit data word. A write packet stores the data word into the addressed register. A read packet records the address, and the next capture strobe loads that register into the data field of the chain so the following shift sequence carries it out.

The register file holds six registers for each watchpoint unit: address value, address mask, data value, data mask, control value and control mask. Every register is presented in parallel on a flat configuration bus for the comparators. Control registers are narrower than the data path. Addresses that select no register are harmless: a write to one changes nothing, and a read from one returns zero.

Top module: `wp_scan_port`

## Requirements
- R1: While reset is high, at the next clock edge every chain bit becomes 0, every register becomes 0 (wp_cfg all zero), tdo becomes 0, and the latched read address becomes 0. Address 0 selects no register.
- R2: Packet layout: bit 37 is the direction (1 = write, 0 = read), bits 36:32 are the register address and bits 31:0 are the data. tdo always shows chain bit 0. Each shift edge moves the chain one place toward bit 0 and loads tdi into bit 37, so a packet goes in and comes out least significant bit first.
- R3: Address map: address bits 4:3 hold the unit number plus one (1..NUM_UNITS). Address bits 2:0 select the kind: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value, 5 control mask. Register index = unit*6 + kind, and that register appears on wp_cfg[index*32 +: 32].
- R4: An update edge with bit 37 set writes the data field into the addressed register. The new value shows on wp_cfg from the next cycle on.
- R5: Control value and control mask registers keep only data bits 7:0. Their bits 31:8 always read as zero.
- R6: An update edge with bit 37 clear latches the address. A later capture edge loads that register's value into chain bits 31:0 and leaves bits 37:32 unchanged.
- R7: Addresses with unit field 0, a unit field above NUM_UNITS, or kind 6 or 7 are unmapped. A write to one leaves every register unchanged, and a read from one returns zero.
- R8: Strobe priority is update, then capture, then shift. During an update edge the chain holds and any capture or shift in that cycle is ignored. During a capture edge, shift is ignored.
- R9: With no strobe active, the chain holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Shift strobe: move the chain one bit |
| capture_en | input | 1 | Capture strobe: load read data into the chain |
| update_en | input | 1 | Update strobe: act on the packet in the chain |
| tdi | input | 1 | Serial input, enters chain bit 37 |
| tdo | output | 1 | Serial output, chain bit 0 |
| wp_cfg | output | NUM_UNITS*6*32 | Parallel contents of all watchpoint registers |

## Verification
The bench writes a distinct word to every one of the 32 addresses and then reads every address back. This catches a design that decodes the unit or kind fields wrongly, lets an unmapped write alias onto a real register, or fails to clear the upper control bits. Each read-back also checks the six bits above the data field, which exposes a capture that overwrites the address or direction bits. A read of the address just after reset shows whether the latched address reset to an unmapped value. One update is issued with capture and shift also active. That packet is then shifted out unchanged, which catches a design that lets a lower-priority strobe corrupt the chain. Idle cycles placed before each shift-out catch a chain that drifts without a strobe.

// File: rtl/wp_scan_pkg.sv
package wp_scan_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int KINDS   = 6;
    localparam int CTRL_W  = 8;
    localparam int IDX_W   = 8;
    localparam int CHAIN_W = DATA_W + ADDR_W + 1;

    // Register kinds within one unit
    typedef enum logic [2:0] {
        K_ADDR_VAL = 3'd0,
        K_ADDR_MSK = 3'd1,
        K_DATA_VAL = 3'd2,
        K_DATA_MSK = 3'd3,
        K_CTRL_VAL = 3'd4,
        K_CTRL_MSK = 3'd5
    } wp_kind_e;

    // Packet as it sits in the chain: direction on top, data at the bottom
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wp_packet_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } wp_sel_t;

    function automatic logic wp_hit(input logic [ADDR_W-1:0] a, input int units);
        logic [1:0] u;
        logic [2:0] k;
        u = a[4:3];
        k = a[2:0];
        return (u != 2'd0) && (int'(u) <= units) && (int'(k) < KINDS);
    endfunction

    function automatic wp_sel_t wp_decode(input logic [ADDR_W-1:0] a, input int units);
        wp_sel_t s;
        s.hit = wp_hit(a, units);
        s.idx = IDX_W'((int'(a[4:3]) - 1) * KINDS + int'(a[2:0]));
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] wp_trim(input logic [DATA_W-1:0] d, input bit is_ctrl);
        return is_ctrl ? DATA_W'(d[CTRL_W-1:0]) : d;
    endfunction

endpackage

// File: rtl/wp_scan_shreg.sv
module wp_scan_shreg
    import wp_scan_pkg::*;
#(
    parameter int LEN = CHAIN_W,
    parameter int DW  = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           capture_en,
    input  logic           update_en,
    input  logic           tdi,
    input  logic [DW-1:0]  cap_data,
    output logic [LEN-1:0] chain_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else if (update_en) begin
            chain_q <= chain_q;
        end else if (capture_en) begin
            chain_q[DW-1:0] <= cap_data;
        end else if (shift_en) begin
            chain_q <= {tdi, chain_q[LEN-1:1]};
        end
    end

endmodule

// File: rtl/wp_regfile.sv
module wp_regfile
    import wp_scan_pkg::*;
#(
    parameter int NUM_UNITS = 2,
    parameter int DW        = DATA_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DW-1:0]             rd_data,
    output logic [NUM_UNITS*KINDS*DW-1:0] cfg
);

    localparam int NREGS = NUM_UNITS * KINDS;

    logic [DW-1:0] regs [NREGS];
    wp_sel_t       wsel;
    wp_sel_t       rsel;

    assign wsel = wp_decode(wr_addr, NUM_UNITS);
    assign rsel = wp_decode(rd_addr, NUM_UNITS);

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam bit IS_CTRL = (g % KINDS) >= int'(K_CTRL_VAL);

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_en && wsel.hit && (wsel.idx == IDX_W'(g))) begin
                regs[g] <= wp_trim(wr_data, IS_CTRL);
            end
        end

        assign cfg[g*DW +: DW] = regs[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (rsel.hit && (rsel.idx == IDX_W'(i))) begin
                rd_data = regs[i];
            end
        end
    end

endmodule

// File: rtl/wp_scan_port.sv
module wp_scan_port
    import wp_scan_pkg::*;
#(
    parameter int NUM_UNITS = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              shift_en,
    input  logic                              capture_en,
    input  logic                              update_en,
    input  logic                              tdi,
    output logic                              tdo,
    output logic [NUM_UNITS*KINDS*DATA_W-1:0] wp_cfg
);

    localparam int LEN = CHAIN_W;

    logic [LEN-1:0]    chain_q;
    wp_packet_t        pkt;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [DATA_W-1:0] rd_data;
    logic              wr_go;

    assign pkt   = chain_q;
    assign wr_go = update_en && pkt.wr;
    assign tdo   = chain_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_addr_q <= '0;
        end else if (update_en && !pkt.wr) begin
            rd_addr_q <= pkt.addr;
        end
    end

    wp_scan_shreg #(.LEN(LEN), .DW(DATA_W)) u_chain (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .tdi        (tdi),
        .cap_data   (rd_data),
        .chain_q    (chain_q)
    );

    wp_regfile #(.NUM_UNITS(NUM_UNITS), .DW(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_go),
        .wr_addr (pkt.addr),
        .wr_data (pkt.data),
        .rd_addr (rd_addr_q),
        .rd_data (rd_data),
        .cfg     (wp_cfg)
    );

endmodule

// File: rtl/wp_scan_port_chk.sv
module wp_scan_port_chk
    import wp_scan_pkg::*;
#(
    parameter int NUM_UNITS = 2
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              shift_en,
    input logic                              capture_en,
    input logic                              update_en,
    input logic                              tdi,
    input logic [CHAIN_W-1:0]                chain_q,
    input logic [DATA_W-1:0]                 rd_data,
    input logic [NUM_UNITS*KINDS*DATA_W-1:0] wp_cfg
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (chain_q == '0) && (wp_cfg == '0));

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !capture_en && !update_en)
        |=> chain_q == {$past(tdi), $past(chain_q[CHAIN_W-1:1])});

    // R6
    capture_load_chk: assert property (@(posedge clk) disable iff (rst)
        (capture_en && !update_en)
        |=> (chain_q[DATA_W-1:0] == $past(rd_data))
            && (chain_q[CHAIN_W-1:DATA_W] == $past(chain_q[CHAIN_W-1:DATA_W])));

    // R8
    update_hold_chk: assert property (@(posedge clk) disable iff (rst)
        update_en |=> $stable(chain_q));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !capture_en && !update_en) |=> $stable(chain_q));

    // R7
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (update_en && chain_q[CHAIN_W-1]
            && !wp_hit(chain_q[CHAIN_W-2:DATA_W], NUM_UNITS))
        |=> $stable(wp_cfg));

endmodule

bind wp_scan_port wp_scan_port_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (shift_en),
    .capture_en (capture_en),
    .update_en  (update_en),
    .tdi        (tdi),
    .chain_q    (chain_q),
    .rd_data    (rd_data),
    .wp_cfg     (wp_cfg)
);

// File: tb/wp_scan_port_test.sv
module wp_scan_port_test;

    localparam int UNITS = 2;
    localparam int NREG  = UNITS * 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
    logic tdo;
    logic [NREG*32-1:0] wp_cfg;

    int errors = 0;
    int checks = 0;
    logic [31:0] model [NREG];

    always #2 clk = ~clk;

    wp_scan_port #(.NUM_UNITS(UNITS)) uut (
        .clk(clk), .rst(rst), .shift_en(shift_en), .capture_en(capture_en),
        .update_en(update_en), .tdi(tdi), .tdo(tdo), .wp_cfg(wp_cfg)
    );

    function automatic bit mapped(input logic [4:0] a);
        return (a[4:3] != 2'd0) && (int'(a[4:3]) <= UNITS) && (int'(a[2:0]) < 6);
    endfunction

    function automatic int index_of(input logic [4:0] a);
        return (int'(a[4:3]) - 1) * 6 + int'(a[2:0]);
    endfunction

    function automatic logic [31:0] pattern(input int a);
        return 32'h9E37_79B9 * (a + 1) ^ 32'h0F0F_3C3C;
    endfunction

    function automatic logic [NREG*32-1:0] model_flat();
        logic [NREG*32-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*32 +: 32] = model[i];
        return f;
    endfunction

    task automatic check(input string req, input logic [383:0] got, input logic [383:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic shift_bits(input logic [37:0] din, output logic [37:0] dout);
        for (int i = 0; i < 38; i++) begin
            dout[i]  = tdo;
            tdi      = din[i];
            shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en = 1'b0;
        tdi      = 1'b0;
    endtask

    task automatic pulse(input logic u, input logic c, input logic s);
        update_en = u; capture_en = c; shift_en = s;
        @(negedge clk);
        update_en = 1'b0; capture_en = 1'b0; shift_en = 1'b0;
    endtask

    task automatic write_reg(input logic [4:0] a, input logic [31:0] d);
        logic [37:0] junk;
        shift_bits({1'b1, a, d}, junk);
        pulse(1'b1, 1'b0, 1'b0);
    endtask

    task automatic read_reg(input logic [4:0] a, output logic [37:0] got);
        logic [37:0] junk;
        shift_bits({1'b0, a, 32'h0}, junk);
        pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b0, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        shift_bits('0, got);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [37:0] got;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 tdo", 384'(tdo), 384'd0);
        check("R1 cfg", 384'(wp_cfg), 384'd0);

        // R1 R6: capture before any read packet reads unmapped address 0
        pulse(1'b0, 1'b1, 1'b0);
        shift_bits('0, got);
        check("R1 R6 first capture", 384'(got), 384'd0);

        // R3 R4 R5 R7: write every address, compare the parallel bus
        for (int a = 0; a < 32; a++) begin
            logic [4:0] ad;
            ad = 5'(a);
            write_reg(ad, pattern(a));
            if (mapped(ad))
                model[index_of(ad)] = (ad[2:0] >= 3'd4) ? {24'h0, pattern(a)[7:0]} : pattern(a);
            check($sformatf("R4 R5 R7 write addr %0d", a), 384'(wp_cfg), 384'(model_flat()));
        end

        // R2 R3 R6 R7 R9: read every address back through the chain
        for (int a = 0; a < 32; a++) begin
            logic [4:0] ad;
            logic [31:0] ed;
            ad = 5'(a);
            ed = mapped(ad) ? model[index_of(ad)] : 32'h0;
            read_reg(ad, got);
            check($sformatf("R2 R6 R7 read addr %0d", a), 384'(got), 384'({1'b0, ad, ed}));
        end

        // R8: update together with capture and shift leaves the chain untouched
        begin
            logic [37:0] junk;
            logic [37:0] pk;
            shift_bits({1'b0, 5'd8, 32'h0}, junk);
            pulse(1'b1, 1'b0, 1'b0);
            pk = {1'b1, 5'd17, 32'hDEAD_BEEF};
            shift_bits(pk, junk);
            pulse(1'b1, 1'b1, 1'b1);
            model[index_of(5'd17)] = 32'hDEAD_BEEF;
            check("R8 update wins cfg", 384'(wp_cfg), 384'(model_flat()));
            shift_bits('0, got);
            check("R8 update wins chain", 384'(got), 384'(pk));
        end

        // R8: capture beats shift in the same cycle
        begin
            logic [37:0] junk;
            shift_bits({1'b0, 5'd17, 32'h0}, junk);
            pulse(1'b1, 1'b0, 1'b0);
            tdi = 1'b1;
            pulse(1'b0, 1'b1, 1'b1);
            tdi = 1'b0;
            shift_bits('0, got);
            check("R8 capture wins", 384'(got), 384'({1'b0, 5'd17, 32'hDEAD_BEEF}));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule